// File: doc/BRIEF.md
# Banked Memory Address Translator

This block turns a 12-bit logical address into a physical address for one of two memories. One is a 2,048-word erasable (RAM) store. The other is a 36,864-word fixed (ROM) store. The logical space is divided into windows:

- Some windows always reach the same words.
- Other windows reach a bank picked by a bank-select register.

There are two such registers, one for erasable banks and one for fixed banks. A third register address gives a combined view of both. Software writes and reads all three through a small register port.

Each cycle the block takes a logical address and the current bank state, decodes which window the address falls in, and registers the result. The result is the physical erasable address, the physical fixed address, a one-hot region select, a flag for aliased windows, and a flag for an out-of-range fixed bank. The memories themselves and instruction fetch sit outside this block.

Top module: `bank_xlate`

## Requirements
- R1: Synchronous active-high reset clears both bank registers to zero, sets erase_addr, fixed_addr, alias_hit and bad_bank to zero, and sets region_sel to 2'b01.
- R2: Logical 0000–0377 octal selects erasable, with erase_addr equal to the low 8 address bits, whatever the bank registers hold.
- R3: Logical 0400–0777 octal selects erasable, with erase_addr = erasable_bank*256 + low 8 address bits.
- R4: Logical 1000–1777 octal behaves exactly as the address with bit 9 cleared (0000–0777) and raises alias_hit.
- R5: Logical 2000–3777 octal selects fixed, with fixed_addr = 2*1024 + low 10 address bits, independent of the fixed bank register.
- R6: Logical 4000–5777 octal selects fixed, with fixed_addr = fixed_bank*1024 + low 10 address bits.
- R7: Logical 6000–7777 octal behaves exactly as the address with bit 10 cleared and raises alias_hit.
- R8: In the switched fixed window, a fixed bank number of 36 or more raises bad_bank and uses bank 0 instead.
- R9: Register address 3 holds the 3-bit erasable bank in data bits [10:8]. Register address 4 holds the 6-bit fixed bank, with its low five bits in data bits [14:10] and its top bit in data bit [6]. Other bits read as zero. Writes to any register address other than 3, 4 and 6 change nothing, and such addresses read as zero.
- R10: Register address 6 holds both banks: fixed bits placed as at address 4, erasable bank in bits [2:0]. A write there updates both banks in one cycle, and a write to address 3 or 4 is seen in the next read of address 6.
- R11: region_sel is always one-hot, with bit 0 meaning erasable and bit 1 meaning fixed.
- R12: All translation outputs and rd_data are registered one cycle after their inputs. They use the bank state held before any write at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| log_addr | input | 12 | Logical address to translate |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| wr_data | input | 15 | Register write data |
| rd_data | output | 15 | Registered register read data |
| erase_addr | output | 11 | Physical erasable address |
| fixed_addr | output | 16 | Physical fixed address |
| region_sel | output | 2 | One-hot region select (bit 0 erasable, bit 1 fixed) |
| alias_hit | output | 1 | Address fell in an aliased window |
| bad_bank | output | 1 | Fixed bank number out of range, bank 0 used |

## Verification
A bank register holding the wrong value shows up in two places:

- The next translation in a switched window carries the wrong bank in the upper bits of erase_addr or fixed_addr.
- The next read of either the single register or the combined register returns the wrong value.

Both show one cycle after the stimulus, because every output is one register deep. A decode error appears in the same cycle as a wrong region_sel or a wrong alias flag. Random mixes of writes and translations, including writes and reads at the same edge, expose any mismatch within a single step.

// File: rtl/bank_xlate_pkg.sv
package bank_xlate_pkg;
  // Region select encoding, one-hot.
  localparam logic [1:0] REGION_ERASE = 2'b01;
  localparam logic [1:0] REGION_FIXED = 2'b10;

  typedef struct packed {
    logic is_fixed;
    logic is_alias;
    logic is_bad;
  } xl_flags_t;
endpackage

// File: rtl/bank_regs.sv
module bank_regs #(
  parameter int WORD_W     = 15,
  parameter int EB_W       = 3,
  parameter int FB_W       = 6,
  parameter int EB_LSB     = 8,
  parameter int FB_LSB     = 10,
  parameter int FB_EXT_BIT = 6,
  parameter int CB_EB_LSB  = 0,
  parameter int RA_W       = 3,
  parameter int RA_EB      = 3,
  parameter int RA_FB      = 4,
  parameter int RA_BB      = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic [EB_W-1:0]   eb_o,
  output logic [FB_W-1:0]   fb_o
);
  localparam int FB_LO_W = FB_W - 1;

  logic [EB_W-1:0]   eb_q;
  logic [FB_W-1:0]   fb_q;
  logic [WORD_W-1:0] view_eb, view_fb, view_bb, view_sel, rd_q;
  logic              hit_eb, hit_fb, hit_bb;
  logic              unused_wbits;

  assign hit_eb = (reg_addr == RA_W'(RA_EB));
  assign hit_fb = (reg_addr == RA_W'(RA_FB));
  assign hit_bb = (reg_addr == RA_W'(RA_BB));
  assign unused_wbits = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      eb_q <= '0;
      fb_q <= '0;
    end else if (wr_en) begin
      if (hit_eb) begin
        eb_q <= wr_data[EB_LSB +: EB_W];
      end else if (hit_fb) begin
        fb_q <= {wr_data[FB_EXT_BIT], wr_data[FB_LSB +: FB_LO_W]};
      end else if (hit_bb) begin
        fb_q <= {wr_data[FB_EXT_BIT], wr_data[FB_LSB +: FB_LO_W]};
        eb_q <= wr_data[CB_EB_LSB +: EB_W];
      end
    end
  end

  always_comb begin
    view_eb = '0;
    view_eb[EB_LSB +: EB_W] = eb_q;
    view_fb = '0;
    view_fb[FB_LSB +: FB_LO_W] = fb_q[FB_LO_W-1:0];
    view_fb[FB_EXT_BIT] = fb_q[FB_W-1];
    view_bb = view_fb;
    view_bb[CB_EB_LSB +: EB_W] = eb_q;
    if (hit_eb)      view_sel = view_eb;
    else if (hit_fb) view_sel = view_fb;
    else if (hit_bb) view_sel = view_bb;
    else             view_sel = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= view_sel;
  end

  assign rd_data = rd_q;
  assign eb_o    = eb_q;
  assign fb_o    = fb_q;

  // R10: a combined write loads both banks in the same cycle
  a_r10_combined_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit_bb) |=> (eb_q == $past(wr_data[CB_EB_LSB +: EB_W]) &&
                           fb_q[FB_LO_W-1:0] == $past(wr_data[FB_LSB +: FB_LO_W])));

  // R9: no write strobe, no bank change
  a_r9_hold_no_write: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(eb_q) && $stable(fb_q)));

  // R9: writes to unmapped register addresses change nothing
  a_r9_unmapped_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !hit_eb && !hit_fb && !hit_bb) |=> ($stable(eb_q) && $stable(fb_q)));
endmodule

// File: rtl/addr_map.sv
module addr_map
  import bank_xlate_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int EB_W         = 3,
  parameter int FB_W         = 6,
  parameter int ERASE_OFF_W  = 8,
  parameter int FIXED_OFF_W  = 10,
  parameter int FBANK_COUNT  = 36,
  parameter int COMMON_FBANK = 2
) (
  input  logic [ADDR_W-1:0]            log_addr,
  input  logic [EB_W-1:0]              eb,
  input  logic [FB_W-1:0]              fb,
  output logic [EB_W+ERASE_OFF_W-1:0]  erase_addr,
  output logic [FB_W+FIXED_OFF_W-1:0]  fixed_addr,
  output xl_flags_t                    flags
);
  localparam int SWFX_BIT  = ADDR_W - 1;
  localparam int COMF_BIT  = FIXED_OFF_W;
  localparam int ALIAS_BIT = ERASE_OFF_W + 1;
  localparam int SWER_BIT  = ERASE_OFF_W;

  logic          in_swfx, in_comf, bank_oob;
  logic [FB_W-1:0] fbank;

  assign in_swfx  = log_addr[SWFX_BIT];
  assign in_comf  = !log_addr[SWFX_BIT] && log_addr[COMF_BIT];
  assign bank_oob = (fb >= FB_W'(FBANK_COUNT));

  always_comb begin
    erase_addr = '0;
    fixed_addr = '0;
    flags      = '0;
    fbank      = '0;
    if (in_swfx) begin
      fbank          = bank_oob ? '0 : fb;
      flags.is_fixed = 1'b1;
      flags.is_alias = log_addr[COMF_BIT];
      flags.is_bad   = bank_oob;
      fixed_addr     = {fbank, log_addr[FIXED_OFF_W-1:0]};
    end else if (in_comf) begin
      flags.is_fixed = 1'b1;
      fixed_addr     = {FB_W'(COMMON_FBANK), log_addr[FIXED_OFF_W-1:0]};
    end else begin
      flags.is_alias = log_addr[ALIAS_BIT];
      if (log_addr[SWER_BIT])
        erase_addr = {eb, log_addr[ERASE_OFF_W-1:0]};
      else
        erase_addr = {{EB_W{1'b0}}, log_addr[ERASE_OFF_W-1:0]};
    end
  end

  // R8: an out-of-range bank is flagged only inside the fixed space
  always_comb begin
    if (flags.is_bad) a_r8_bad_only_fixed: assert (flags.is_fixed);
  end
endmodule

// File: rtl/bank_xlate.sv
module bank_xlate
  import bank_xlate_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int WORD_W       = 15,
  parameter int EB_W         = 3,
  parameter int FB_W         = 6,
  parameter int ERASE_OFF_W  = 8,
  parameter int FIXED_OFF_W  = 10,
  parameter int FBANK_COUNT  = 36,
  parameter int COMMON_FBANK = 2,
  parameter int RA_W         = 3,
  localparam int EA_W        = EB_W + ERASE_OFF_W,
  localparam int FA_W        = FB_W + FIXED_OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] log_addr,
  input  logic              wr_en,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic [EA_W-1:0]   erase_addr,
  output logic [FA_W-1:0]   fixed_addr,
  output logic [1:0]        region_sel,
  output logic              alias_hit,
  output logic              bad_bank
);
  logic [EB_W-1:0] eb;
  logic [FB_W-1:0] fb;
  logic [EA_W-1:0] ea_c, ea_q;
  logic [FA_W-1:0] fa_c, fa_q;
  xl_flags_t       fl_c;
  logic [1:0]      reg_q;
  logic            al_q, bad_q, seen_q;

  bank_regs #(
    .WORD_W(WORD_W), .EB_W(EB_W), .FB_W(FB_W), .RA_W(RA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .eb_o(eb), .fb_o(fb)
  );

  addr_map #(
    .ADDR_W(ADDR_W), .EB_W(EB_W), .FB_W(FB_W), .ERASE_OFF_W(ERASE_OFF_W),
    .FIXED_OFF_W(FIXED_OFF_W), .FBANK_COUNT(FBANK_COUNT),
    .COMMON_FBANK(COMMON_FBANK)
  ) u_map (
    .log_addr(log_addr), .eb(eb), .fb(fb),
    .erase_addr(ea_c), .fixed_addr(fa_c), .flags(fl_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_q   <= '0;
      fa_q   <= '0;
      reg_q  <= REGION_ERASE;
      al_q   <= 1'b0;
      bad_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      ea_q   <= ea_c;
      fa_q   <= fa_c;
      reg_q  <= fl_c.is_fixed ? REGION_FIXED : REGION_ERASE;
      al_q   <= fl_c.is_alias;
      bad_q  <= fl_c.is_bad;
      seen_q <= 1'b1;
    end
  end

  assign erase_addr = ea_q;
  assign fixed_addr = fa_q;
  assign region_sel = reg_q;
  assign alias_hit  = al_q;
  assign bad_bank   = bad_q;

  // R11: exactly one region selected
  a_r11_region_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(region_sel) == 1);

  // R8: a forced bank leaves the upper fixed address bits at zero
  a_r8_bad_forces_zero: assert property (@(posedge clk) disable iff (rst)
    bad_bank |-> (region_sel == REGION_FIXED && fixed_addr[FA_W-1:FIXED_OFF_W] == '0));

  // R2: unswitched erasable window ignores the bank registers
  a_r2_unswitched: assert property (@(posedge clk) disable iff (rst)
    (seen_q && $past(log_addr) < ADDR_W'(1 << ERASE_OFF_W)) |->
      (region_sel == REGION_ERASE &&
       erase_addr == EA_W'($past(log_addr[ERASE_OFF_W-1:0]))));

  // R5: common fixed window always lands in the common bank
  a_r5_common_fixed: assert property (@(posedge clk) disable iff (rst)
    (seen_q && $past(log_addr[ADDR_W-1:FIXED_OFF_W]) == 2'b01) |->
      (region_sel == REGION_FIXED && !alias_hit &&
       fixed_addr[FA_W-1:FIXED_OFF_W] == FB_W'(COMMON_FBANK)));
endmodule

// File: tb/bank_xlate_test.sv
module bank_xlate_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] log_addr = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [14:0] wr_data = '0;
  logic [14:0] rd_data;
  logic [10:0] erase_addr;
  logic [15:0] fixed_addr;
  logic [1:0]  region_sel;
  logic        alias_hit, bad_bank;

  int checks = 0;
  int errors = 0;
  logic [2:0] m_eb = '0;
  logic [5:0] m_fb = '0;

  always #10 clk = ~clk;

  bank_xlate uut (
    .clk(clk), .rst(rst), .log_addr(log_addr), .wr_en(wr_en),
    .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data),
    .erase_addr(erase_addr), .fixed_addr(fixed_addr),
    .region_sel(region_sel), .alias_hit(alias_hit), .bad_bank(bad_bank)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [14:0] view(input logic [2:0] ra,
                                       input logic [2:0] eb,
                                       input logic [5:0] fb);
    logic [14:0] v;
    v = '0;
    if (ra == 3'd3) v[10:8] = eb;
    else if (ra == 3'd4 || ra == 3'd6) begin
      v[14:10] = fb[4:0];
      v[6]     = fb[5];
      if (ra == 3'd6) v[2:0] = eb;
    end
    return v;
  endfunction

  function automatic string win_tag(input logic [11:0] a, input logic [5:0] fb);
    if (a[11] && fb >= 6'd36) return "R8";
    if (a < 12'o0400) return "R2";
    if (a < 12'o1000) return "R3";
    if (a < 12'o2000) return "R4";
    if (a < 12'o4000) return "R5";
    if (a < 12'o6000) return "R6";
    return "R7";
  endfunction

  // One clock step; outputs checked after the edge (R12: one-cycle latency,
  // using bank state held before any write at the same edge).
  task automatic step(input logic we, input logic [2:0] ra,
                      input logic [14:0] wd, input logic [11:0] la,
                      input string rtag);
    logic [10:0] e_ea;
    logic [15:0] e_fa;
    logic [1:0]  e_rg;
    logic        e_al, e_bad;
    logic [5:0]  bk;
    logic [14:0] e_rd;
    string       t;
    @(negedge clk);
    wr_en = we; reg_addr = ra; wr_data = wd; log_addr = la;
    e_ea = '0; e_fa = '0; e_al = 1'b0; e_bad = 1'b0;
    if (la[11]) begin
      e_rg = 2'b10; e_al = la[10];
      e_bad = (m_fb >= 6'd36);
      bk = e_bad ? 6'd0 : m_fb;
      e_fa = {bk, la[9:0]};
    end else if (la[10]) begin
      e_rg = 2'b10;
      e_fa = {6'd2, la[9:0]};
    end else begin
      e_rg = 2'b01; e_al = la[9];
      e_ea = la[8] ? {m_eb, la[7:0]} : {3'b000, la[7:0]};
    end
    e_rd = view(ra, m_eb, m_fb);
    t = win_tag(la, m_fb);
    @(posedge clk);
    #2;
    chk(t, "erase_addr", 32'(erase_addr), 32'(e_ea));
    chk(t, "fixed_addr", 32'(fixed_addr), 32'(e_fa));
    chk("R11", "region_sel", 32'(region_sel), 32'(e_rg));
    chk(t, "alias_hit", 32'(alias_hit), 32'(e_al));
    chk("R8", "bad_bank", 32'(bad_bank), 32'(e_bad));
    chk(rtag, "rd_data", 32'(rd_data), 32'(e_rd));
    if (we) begin
      if (ra == 3'd3) m_eb = wd[10:8];
      else if (ra == 3'd4) m_fb = {wd[6], wd[14:10]};
      else if (ra == 3'd6) begin
        m_fb = {wd[6], wd[14:10]};
        m_eb = wd[2:0];
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state at the outputs
    chk("R1", "erase_addr", 32'(erase_addr), 0);
    chk("R1", "fixed_addr", 32'(fixed_addr), 0);
    chk("R1", "region_sel", 32'(region_sel), 32'h1);
    chk("R1", "alias_hit", 32'(alias_hit), 0);
    chk("R1", "bad_bank", 32'(bad_bank), 0);
    chk("R1", "rd_data", 32'(rd_data), 0);
    @(negedge clk);
    rst = 1'b0;
    // R1: registers read back zero after reset
    step(0, 3'd3, '0, 12'o0000, "R1");
    step(0, 3'd4, '0, 12'o4000, "R1");
    step(0, 3'd6, '0, 12'o0400, "R1");
    // R9: erasable bank register, then R2 ignores it, R3 uses it
    step(1, 3'd3, 15'h0500, 12'o0123, "R9");
    step(0, 3'd3, '0, 12'o0123, "R9");
    step(0, 3'd6, '0, 12'o0777, "R10");
    step(0, 3'd0, '0, 12'o1456, "R4");
    // R9: fixed bank 35 (low 3 in [14:10], top bit in [6])
    step(1, 3'd4, {5'd3, 3'b000, 1'b1, 6'd0}, 12'o2001, "R9");
    step(0, 3'd4, '0, 12'o4321, "R6");
    step(0, 3'd6, '0, 12'o6321, "R10");
    // R8: bank 36 and bank 63
    step(1, 3'd4, {5'd4, 3'b000, 1'b1, 6'd0}, 12'o4000, "R9");
    step(0, 3'd0, '0, 12'o7777, "R8");
    step(1, 3'd6, {5'd31, 3'b000, 1'b1, 3'b000, 3'd7}, 12'o5555, "R10");
    step(0, 3'd6, '0, 12'o4001, "R10");
    step(0, 3'd0, '0, 12'o0777, "R3");
    // R9: unmapped register address writes ignored, reads zero
    step(1, 3'd5, 15'h7fff, 12'o3777, "R9");
    step(1, 3'd7, 15'h7fff, 12'o0000, "R9");
    step(0, 3'd5, '0, 12'o0000, "R9");
    step(0, 3'd6, '0, 12'o4000, "R10");
    // R12: read of combined register at the write edge shows old value
    step(1, 3'd6, 15'h0002, 12'o0400, "R12");
    step(0, 3'd6, '0, 12'o0400, "R12");
    // R10: single write seen in combined read
    step(1, 3'd3, 15'h0300, 12'o2000, "R10");
    step(0, 3'd6, '0, 12'o0401, "R10");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] ra;
      ra = 3'($urandom_range(0, 7));
      step(($urandom_range(0, 2) == 0), ra, 15'($urandom),
           12'($urandom), (ra == 3'd6) ? "R10" : "R9");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule